// File: doc/BRIEF.md
# Link Reset Control Word Handler

This block runs the reset handshake that rides in a single bit of a control word recurring once per hyperframe on a radio fronthaul link. The same bit carries a reset request in one direction and the acknowledge in the other. The framer samples the received bit once per hyperframe and presents it together with a one-cycle hyperframe strobe. The framer also takes the bit to transmit from this block.

In master role the block sends a request for one of two reasons. Software may force it through the configuration fields, and the request then stops when the partner's acknowledge is confirmed. Otherwise a hardware input drives it directly. In slave role the block waits until the request bit has arrived in four hyperframes in a row before it reports a confirmed request. It then answers with an acknowledge that lasts ten hyperframes, or mirrors the hardware input when hardware control is selected. It can also raise a reset request towards the application. A synchronous block reset ends that request and clears all state.

Top module: `link_rst_ctrl`

## Requirements
- R1: A received reset bit of 1 counts as a confirmed request (`st_detect` = 1) only once it has been sampled on four consecutive hyperframe strobes. The bit is sampled only when `hf_strobe` = 1. After three such strobes `st_detect` stays 0.
- R2: A strobe that samples `rx_rst_bit` = 0 restarts the count of consecutive hyperframes and drops `st_detect` to 0.
- R3: `st_detect_hold` becomes 1 with `st_detect` and stays 1 after `st_detect` falls, until a cycle with `clr_detect_hold` = 1 clears it.
- R4: In slave role (`role_master` = 0) with `cfg_gen_en` = 1 and `cfg_hw_en` = 0, a confirmed request makes `tx_rst_bit` equal 1 on exactly ten consecutive hyperframe strobes, after which it returns to 0.
- R5: Once the tenth acknowledge hyperframe has been sent, `st_done` and `st_done_hold` become 1. `st_done` falls when the received request ends. `st_done_hold` stays 1 until a cycle with `clr_done_hold` = 1.
- R6: In slave role with `cfg_hw_en` = 1, `cfg_gen_en` has no effect. `tx_rst_bit` follows `hw_rst_in` one cycle later, and no ten-hyperframe acknowledge or `st_done` occurs.
- R7: In master role with `cfg_gen_en` = 1, `cfg_gen_force` = 1 and `cfg_hw_en` = 0, `tx_rst_bit` is 1 until an acknowledge is confirmed on the receive side (four consecutive received 1s). It is then 0 while both fields stay set.
- R8: In master role with `cfg_hw_en` = 0, clearing `cfg_gen_en` drops `tx_rst_bit` to 0 on the next cycle, which aborts a forced request.
- R9: In master role with `cfg_hw_en` = 1, `tx_rst_bit` follows `hw_rst_in` one cycle later, and `cfg_gen_force` has no effect.
- R10: In slave role with `cfg_out_en` = 1, a confirmed request sets `app_rst_req` to 1, which then holds until the block reset. With `cfg_out_en` = 0 it stays 0.
- R11: The synchronous reset `rst` = 1 clears `tx_rst_bit`, every status output and `app_rst_req` to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| hf_strobe | input | 1 | One-cycle pulse per hyperframe; the received bit is sampled on it |
| rx_rst_bit | input | 1 | Reset bit of the current received hyperframe |
| hw_rst_in | input | 1 | Hardware reset assert input |
| cfg_gen_en | input | 1 | Enables software-generated request / acknowledge |
| cfg_gen_force | input | 1 | Forces a request in master role |
| cfg_hw_en | input | 1 | Selects hardware-driven control; overrides cfg_gen_en |
| cfg_out_en | input | 1 | Enables the reset request to the application |
| clr_detect_hold | input | 1 | Write-1 pulse clearing st_detect_hold |
| clr_done_hold | input | 1 | Write-1 pulse clearing st_done_hold |
| tx_rst_bit | output | 1 | Reset bit to place in the outgoing hyperframe |
| st_detect | output | 1 | Live confirmed-request (or confirmed-acknowledge) status |
| st_detect_hold | output | 1 | Sticky copy of st_detect |
| st_done | output | 1 | Live acknowledge-sequence-finished status |
| st_done_hold | output | 1 | Sticky copy of st_done |
| app_rst_req | output | 1 | Reset request to the application layer |

## Verification
The embedded properties assume that `hf_strobe` is a single-cycle pulse and that the configuration fields only change between strobes. They also assume `role_master` is fixed between block resets, because the sticky and hold checks do not model a role change mid-handshake. The directed tasks respect this. They pulse the strobe for one cycle followed by idle cycles, change the configuration only at idle points, and issue a block reset before every scenario so that each role and enable combination starts from the cleared state.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  typedef struct packed {
    logic gen_en;
    logic gen_force;
    logic hw_en;
    logic out_en;
  } lrc_cfg_t;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_RUN  = 2'd1,
    ACK_DONE = 2'd2
  } ack_state_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lrc_rx_confirm.sv
module lrc_rx_confirm #(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hf_strobe,
  input  logic rx_bit,
  output logic confirmed
);
  import lrc_pkg::*;

  localparam int unsigned CW = cnt_width(RUN_LEN);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] run_cnt;
  logic          det_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      det_q   <= 1'b0;
    end else if (hf_strobe) begin
      if (rx_bit) begin
        if (run_cnt == LAST) det_q <= 1'b1;
        else                 run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= '0;
        det_q   <= 1'b0;
      end
    end
  end

  assign confirmed = det_q;

  assert_detect_needs_bit_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(confirmed) |-> $past(hf_strobe && rx_bit));

  assert_miss_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (hf_strobe && !rx_bit) |=> !confirmed);

endmodule

// File: rtl/lrc_ack_seq.sv
module lrc_ack_seq #(
  parameter int unsigned ACK_LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic hf_strobe,
  input  logic enable,
  input  logic request,
  output logic ack_active,
  output logic finished
);
  import lrc_pkg::*;

  localparam int unsigned AW = cnt_width(ACK_LEN);
  localparam logic [AW-1:0] LAST = AW'(ACK_LEN - 1);

  ack_state_t    state;
  logic [AW-1:0] sent_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ACK_IDLE;
      sent_cnt <= '0;
    end else begin
      unique case (state)
        ACK_IDLE: begin
          sent_cnt <= '0;
          if (enable && request) state <= ACK_RUN;
        end
        ACK_RUN: begin
          if (!enable) begin
            state <= ACK_IDLE;
          end else if (hf_strobe) begin
            if (sent_cnt == LAST) state <= ACK_DONE;
            else                  sent_cnt <= sent_cnt + 1'b1;
          end
        end
        ACK_DONE: begin
          if (!request) state <= ACK_IDLE;
        end
        default: state <= ACK_IDLE;
      endcase
    end
  end

  assign ack_active = (state == ACK_RUN);
  assign finished   = (state == ACK_DONE);

  assert_done_after_run_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(finished) |-> $past(ack_active && hf_strobe));

  assert_run_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    ack_active |-> (sent_cnt <= LAST));

endmodule

// File: rtl/lrc_sticky.sv
module lrc_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic hold_q;
    always_ff @(posedge clk) begin
      if (rst)         hold_q <= 1'b0;
      else if (set[i]) hold_q <= 1'b1;
      else if (clr[i]) hold_q <= 1'b0;
    end
    assign q[i] = hold_q;

    assert_hold_sticky_R3: assert property (@(posedge clk) disable iff (rst)
      (q[i] && !clr[i]) |=> q[i]);
  end

endmodule

// File: rtl/link_rst_ctrl.sv
module link_rst_ctrl #(
  parameter int unsigned CONFIRM_LEN = 4,
  parameter int unsigned ACK_LEN     = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic role_master,
  input  logic hf_strobe,
  input  logic rx_rst_bit,
  input  logic hw_rst_in,
  input  logic cfg_gen_en,
  input  logic cfg_gen_force,
  input  logic cfg_hw_en,
  input  logic cfg_out_en,
  input  logic clr_detect_hold,
  input  logic clr_done_hold,
  output logic tx_rst_bit,
  output logic st_detect,
  output logic st_detect_hold,
  output logic st_done,
  output logic st_done_hold,
  output logic app_rst_req
);
  import lrc_pkg::*;

  lrc_cfg_t cfg;
  assign cfg = '{gen_en: cfg_gen_en, gen_force: cfg_gen_force,
                 hw_en: cfg_hw_en, out_en: cfg_out_en};

  logic confirmed;
  logic ack_active;
  logic ack_finished;
  logic ack_seen_q;
  logic tx_q;
  logic app_q;
  logic tx_next;
  logic forced_req;
  logic slave_ack_en;
  logic [1:0] hold_q;

  lrc_rx_confirm #(.RUN_LEN(CONFIRM_LEN)) u_confirm (
    .clk       (clk),
    .rst       (rst),
    .hf_strobe (hf_strobe),
    .rx_bit    (rx_rst_bit),
    .confirmed (confirmed)
  );

  assign slave_ack_en = !role_master && cfg.gen_en && !cfg.hw_en;

  lrc_ack_seq #(.ACK_LEN(ACK_LEN)) u_ack (
    .clk        (clk),
    .rst        (rst),
    .hf_strobe  (hf_strobe),
    .enable     (slave_ack_en),
    .request    (confirmed),
    .ack_active (ack_active),
    .finished   (ack_finished)
  );

  // Master: remember a confirmed acknowledge for as long as the forced request stays armed.
  always_ff @(posedge clk) begin
    if (rst)                                                  ack_seen_q <= 1'b0;
    else if (!role_master || cfg.hw_en || !(cfg.gen_en && cfg.gen_force)) ack_seen_q <= 1'b0;
    else if (confirmed)                                       ack_seen_q <= 1'b1;
  end

  assign forced_req = cfg.gen_en && cfg.gen_force && !ack_seen_q;

  always_comb begin
    if (cfg.hw_en)        tx_next = hw_rst_in;
    else if (role_master) tx_next = forced_req;
    else                  tx_next = ack_active;
  end

  always_ff @(posedge clk) begin
    if (rst) tx_q <= 1'b0;
    else     tx_q <= tx_next;
  end

  always_ff @(posedge clk) begin
    if (rst)                                          app_q <= 1'b0;
    else if (!role_master && cfg.out_en && confirmed) app_q <= 1'b1;
  end

  lrc_sticky #(.N(2)) u_hold (
    .clk (clk),
    .rst (rst),
    .set ({ack_finished, confirmed}),
    .clr ({clr_done_hold, clr_detect_hold}),
    .q   (hold_q)
  );

  assign tx_rst_bit     = tx_q;
  assign st_detect      = confirmed;
  assign st_done        = ack_finished;
  assign st_detect_hold = hold_q[0];
  assign st_done_hold   = hold_q[1];
  assign app_rst_req    = app_q;

  assert_hw_prec_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg.hw_en) && cfg.hw_en) |-> (tx_rst_bit == $past(hw_rst_in)));

  assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
    (role_master && !cfg.gen_en && !cfg.hw_en) |=> !tx_rst_bit);

  assert_app_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    app_rst_req |=> app_rst_req);

  assert_no_done_in_hw_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg.hw_en && !ack_finished) |=> !st_done);

endmodule

// File: tb/link_rst_ctrl_tb.sv
module link_rst_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic role_master = 1'b0, hf_strobe = 1'b0, rx_rst_bit = 1'b0, hw_rst_in = 1'b0;
  logic cfg_gen_en = 1'b0, cfg_gen_force = 1'b0, cfg_hw_en = 1'b0, cfg_out_en = 1'b0;
  logic clr_detect_hold = 1'b0, clr_done_hold = 1'b0;
  logic tx_rst_bit, st_detect, st_detect_hold, st_done, st_done_hold, app_rst_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_rst_ctrl u_dut (
    .clk(clk), .rst(rst), .role_master(role_master), .hf_strobe(hf_strobe),
    .rx_rst_bit(rx_rst_bit), .hw_rst_in(hw_rst_in), .cfg_gen_en(cfg_gen_en),
    .cfg_gen_force(cfg_gen_force), .cfg_hw_en(cfg_hw_en), .cfg_out_en(cfg_out_en),
    .clr_detect_hold(clr_detect_hold), .clr_done_hold(clr_done_hold),
    .tx_rst_bit(tx_rst_bit), .st_detect(st_detect), .st_detect_hold(st_detect_hold),
    .st_done(st_done), .st_done_hold(st_done_hold), .app_rst_req(app_rst_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    role_master = 1'b0; rx_rst_bit = 1'b0; hw_rst_in = 1'b0; hf_strobe = 1'b0;
    cfg_gen_en = 1'b0; cfg_gen_force = 1'b0; cfg_hw_en = 1'b0; cfg_out_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // One hyperframe: returns the transmitted bit seen at the strobe edge.
  task automatic hf(input logic b, output logic tx_at_strobe);
    @(negedge clk);
    tx_at_strobe = tx_rst_bit;
    rx_rst_bit = b;
    hf_strobe  = 1'b1;
    @(negedge clk);
    hf_strobe  = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic hf_n(input logic b, input int n);
    logic t;
    for (int i = 0; i < n; i++) hf(b, t);
  endtask

  task automatic test_reset_state();
    do_reset();
    chk("R11 tx after reset", tx_rst_bit, 0);
    chk("R11 detect after reset", st_detect, 0);
    chk("R11 holds after reset", {st_detect_hold, st_done, st_done_hold, app_rst_req}, 0);
  endtask

  task automatic test_confirm();
    do_reset();
    hf_n(1'b1, 3);
    chk("R1 no detect after 3", st_detect, 0);
    hf_n(1'b0, 1);
    hf_n(1'b1, 3);
    chk("R2 gap restarts count", st_detect, 0);
    hf_n(1'b1, 1);
    chk("R1 detect after 4", st_detect, 1);
    chk("R3 hold set", st_detect_hold, 1);
    hf_n(1'b0, 1);
    chk("R2 miss drops detect", st_detect, 0);
    chk("R3 hold stays", st_detect_hold, 1);
    @(negedge clk); clr_detect_hold = 1'b1;
    @(negedge clk); clr_detect_hold = 1'b0;
    chk("R3 hold cleared", st_detect_hold, 0);
  endtask

  task automatic test_slave_ack();
    int ones = 0;
    int first_ten = 0;
    logic t;
    do_reset();
    cfg_gen_en = 1'b1;
    hf_n(1'b1, 4);
    chk("R1 slave detect", st_detect, 1);
    for (int i = 0; i < 13; i++) begin
      hf(1'b1, t);
      if (t) ones++;
      if (i < 10 && t) first_ten++;
    end
    chk("R4 ack count", ones, 10);
    chk("R4 ack consecutive", first_ten, 10);
    chk("R4 tx idle after ack", tx_rst_bit, 0);
    chk("R5 done", st_done, 1);
    chk("R5 done hold", st_done_hold, 1);
    hf_n(1'b0, 1);
    chk("R5 done falls with request", st_done, 0);
    chk("R5 done hold stays", st_done_hold, 1);
    @(negedge clk); clr_done_hold = 1'b1;
    @(negedge clk); clr_done_hold = 1'b0;
    chk("R5 done hold cleared", st_done_hold, 0);
  endtask

  task automatic test_slave_hw();
    int ones = 0;
    logic t;
    do_reset();
    cfg_gen_en = 1'b1; cfg_hw_en = 1'b1;
    hf_n(1'b1, 4);
    for (int i = 0; i < 12; i++) begin
      hf(1'b1, t);
      if (t) ones++;
    end
    chk("R6 no sequence with hw_en", ones, 0);
    chk("R6 no done with hw_en", st_done_hold, 0);
    @(negedge clk); hw_rst_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 tx follows hw input", tx_rst_bit, 1);
    hw_rst_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 tx follows hw low", tx_rst_bit, 0);
  endtask

  task automatic test_master_forced();
    do_reset();
    role_master = 1'b1;
    cfg_gen_en = 1'b1; cfg_gen_force = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 forced request", tx_rst_bit, 1);
    hf_n(1'b1, 3);
    chk("R7 request until ack", tx_rst_bit, 1);
    hf_n(1'b1, 1);
    chk("R7 stop after ack", tx_rst_bit, 0);
    hf_n(1'b0, 2);
    chk("R7 stays stopped", tx_rst_bit, 0);
    cfg_gen_force = 1'b0;
    repeat (2) @(negedge clk);
    cfg_gen_force = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 rearmed request", tx_rst_bit, 1);
    cfg_gen_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 abort by gen_en", tx_rst_bit, 0);
    chk("R10 no app request in master", app_rst_req, 0);
  endtask

  task automatic test_master_hw();
    do_reset();
    role_master = 1'b1;
    cfg_hw_en = 1'b1; cfg_gen_en = 1'b1; cfg_gen_force = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 force ignored under hw_en", tx_rst_bit, 0);
    hw_rst_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 tx follows hw input", tx_rst_bit, 1);
  endtask

  task automatic test_app_req();
    do_reset();
    cfg_out_en = 1'b0;
    hf_n(1'b1, 4);
    chk("R10 no request when disabled", app_rst_req, 0);
    do_reset();
    cfg_out_en = 1'b1;
    hf_n(1'b1, 3);
    chk("R10 no request before confirm", app_rst_req, 0);
    hf_n(1'b1, 1);
    chk("R10 request raised", app_rst_req, 1);
    hf_n(1'b0, 3);
    chk("R10 request held", app_rst_req, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R11 reset ends request", app_rst_req, 0);
    chk("R11 reset clears hold", st_detect_hold, 0);
    rst = 1'b0;
  endtask

  initial begin
    test_reset_state();
    test_confirm();
    test_slave_ack();
    test_slave_hw();
    test_master_forced();
    test_master_hw();
    test_app_req();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule